// File: doc/BRIEF.md
# Fractional Clock-Enable Divider with Committed Updates

This block turns a free-running input clock into a stream of single-cycle clock-enable pulses whose average rate is the input rate divided by a fixed-point divisor. The divisor is held as an unsigned field with `FRAC_W` fractional bits, stored offset by one whole unit: a field of zero means divide by exactly 1.0. An optional integer pre-divider sits in front of the fractional stage, so the output rate is the input rate divided by `PRE_DIV` and then by the fractional divisor. A build option swaps the programmable divisor for a fixed integer divisor that no register write can change.

Software stages a new divisor and a new parent-select code in registers. Neither reaches the running divider until a self-clearing commit bit is set. When the separate parent commit is built in, the parent commit applies the select code and the main commit applies the divisor. Without it, the main commit applies both. A commit completes a fixed `COMMIT_LAT` cycles after it is requested while the clock gate input is high. While the gate is low, the request waits, and no pulses are issued. Each commit restarts the fractional phase from zero.

Top module: `fracdiv_ce`

## Requirements
- R1: With the programmable divisor, the divisor in units of 2^-FRAC_W is D = field + 2^FRAC_W. Starting from a commit, the accumulator gains 2^FRAC_W on each pre-divider tick. `ce_out` is high in the cycle after tick j exactly when floor(j*2^FRAC_W/D) exceeds floor((j-1)*2^FRAC_W/D).
- R2: A write to the divisor register at address 0 changes only the bits whose `bus_wmask` bit is 1. The divisor field sits at bits [FIELD_SHIFT +: FIELD_W], and every other bit of that register is plain storage.
- R3: Staging a new field value changes neither the active divisor nor the pulse rate until a main commit completes.
- R4: Writing 1 to bit 0 of the control register at address 1 requests a main commit. With the gate high, bit 0 reads 1 until the commit, and it reads 0 from `COMMIT_LAT` clock edges after the write edge. The pulse sequence restarts from phase zero at that edge.
- R5: While `gate_on` is low, `ce_out` stays low and a commit request stays pending. Once the gate is high again, the commit completes `COMMIT_LAT` edges later.
- R6: With `FIXED_DIV` > 0, the divisor field is not writable and reads 0. The divider then issues one pulse every `FIXED_DIV` pre-divider ticks, with no fractional scaling.
- R7: Pulses occur only after every `PRE_DIV`-th gated input cycle. After a commit, tick k arrives at edge k*PRE_DIV.
- R8: Control bits [8 +: SEL_W] stage the parent-select code. If `PRE_TRIG_EN` is set, writing 1 to control bit 1 commits the code to `sel_out` and a main commit leaves `sel_out` unchanged. If it is clear, the main commit also applies the code, and bit 1 is ignored and reads 0.
- R9: After reset, both registers read 0, `sel_out` is 0 and the active divisor is 1.0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate_on | input | 1 | Clock gate state; low freezes pulses and commits |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Write address |
| bus_wdata | input | 32 | Write data |
| bus_wmask | input | 32 | Per-bit write mask |
| bus_raddr | input | ADDR_W | Read address |
| bus_rdata | output | 32 | Read data, combinational from `bus_raddr` |
| ce_out | output | 1 | Divided clock-enable pulse |
| sel_out | output | SEL_W | Committed parent-select code |

## Verification
A commit request lands on the write edge, and the commit bit clears exactly `COMMIT_LAT` edges later. The bench reads the bit one cycle after the write edge, again after the next edge, and again after the commit edge. The first pulse after a commit can appear no earlier than `PRE_DIV` edges after the commit edge. The bench therefore checks every cycle of a fixed window against the arithmetic sequence floor(j*2^F/D), sampling just after each edge. When the phase is unknown, it counts pulses over a window that is a whole multiple of the pulse period.

// File: rtl/fracdiv_pkg.sv
package fracdiv_pkg;
   // register addresses
   localparam int REG_DIV     = 0;
   localparam int REG_CTL     = 1;
   // control register bit positions
   localparam int CTL_TRIG    = 0;
   localparam int CTL_PRE     = 1;
   localparam int CTL_SEL_LSB = 8;

   function automatic logic [31:0] field_mask(input int lsb, input int width);
      logic [31:0] m;
      m = '0;
      for (int i = 0; i < 32; i++)
         if (i >= lsb && i < lsb + width) m[i] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/fracdiv_trig.sv
module fracdiv_trig #(
   parameter int LAT = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic gate_on,
   output logic pend,
   output logic fire
);
   localparam int CW = (LAT < 2) ? 1 : $clog2(LAT);

   if (LAT < 1) begin : g_bad_lat
      $error("LAT must be at least 1");
   end

   logic [CW-1:0] cnt;

   assign fire = pend & gate_on & (cnt == CW'(LAT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= 1'b0;
         cnt  <= '0;
      end else if (fire) begin
         pend <= 1'b0;
         cnt  <= '0;
      end else if (pend) begin
         if (gate_on) cnt <= cnt + CW'(1);
      end else if (arm) begin
         pend <= 1'b1;
         cnt  <= '0;
      end
   end

   // R4: a completed commit drops the request bit
   p_fire_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> !pend);
   // R5: a gated-off request is held
   p_hold_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && !gate_on) |=> pend);
endmodule

// File: rtl/fracdiv_pretick.sv
module fracdiv_pretick #(
   parameter int PRE_DIV = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic gate_on,
   input  logic restart,
   output logic tick
);
   if (PRE_DIV < 1) begin : g_bad_pre
      $error("PRE_DIV must be at least 1");
   end

   if (PRE_DIV == 1) begin : g_bypass
      logic unused_in;
      assign unused_in = ^{clk, rst_n, gate_on, restart};
      assign tick = 1'b1;
   end else begin : g_count
      localparam int CW = $clog2(PRE_DIV);
      logic [CW-1:0] cnt;

      assign tick = (cnt == CW'(PRE_DIV - 1));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       cnt <= '0;
         else if (restart) cnt <= '0;
         else if (gate_on) cnt <= tick ? '0 : cnt + CW'(1);
      end

      // R7: the pre-divider count stays inside its ratio
      p_cnt_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
         cnt <= CW'(PRE_DIV - 1));
   end
endmodule

// File: rtl/fracdiv_accum.sv
module fracdiv_accum #(
   parameter int ACC_W = 8,
   parameter int STEP  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic             restart,
   input  logic [ACC_W-1:0] div,
   output logic             ce
);
   if (STEP < 1) begin : g_bad_step
      $error("STEP must be at least 1");
   end

   logic [ACC_W-1:0] acc;
   logic [ACC_W-1:0] sum;
   logic             hit;

   assign sum = acc + ACC_W'(STEP);
   assign hit = (sum >= div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc <= '0;
         ce  <= 1'b0;
      end else if (restart) begin
         acc <= '0;
         ce  <= 1'b0;
      end else if (adv) begin
         ce  <= hit;
         acc <= hit ? sum - div : sum;
      end else begin
         ce  <= 1'b0;
      end
   end

   // R1: the phase never reaches the divisor it is compared with
   p_acc_below_div_r1: assert property (@(posedge clk) disable iff (!rst_n)
      acc < div);
endmodule

// File: rtl/fracdiv_ce.sv
module fracdiv_ce
   import fracdiv_pkg::*;
#(
   parameter int FIELD_W     = 6,
   parameter int FRAC_W      = 3,
   parameter int FIELD_SHIFT = 4,
   parameter int PRE_DIV     = 1,
   parameter int FIXED_DIV   = 0,
   parameter int SEL_W       = 2,
   parameter int PRE_TRIG_EN = 1,
   parameter int COMMIT_LAT  = 2,
   parameter int ADDR_W      = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              gate_on,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   input  logic [31:0]       bus_wmask,
   input  logic [ADDR_W-1:0] bus_raddr,
   output logic [31:0]       bus_rdata,
   output logic              ce_out,
   output logic [SEL_W-1:0]  sel_out
);
   localparam int          ACC_W   = FIELD_W + 2;
   localparam int          ONE     = 1 << FRAC_W;
   localparam int          STEP    = (FIXED_DIV > 0) ? 1 : ONE;
   localparam logic [31:0] FMASK   = field_mask(FIELD_SHIFT, FIELD_W);
   localparam logic [31:0] WR_MASK = (FIXED_DIV > 0) ? ~FMASK : 32'hFFFF_FFFF;

   if (FRAC_W > FIELD_W) begin : g_bad_frac
      $error("FRAC_W may not exceed FIELD_W");
   end
   if (FIELD_SHIFT + FIELD_W > 32) begin : g_bad_field
      $error("divisor field exceeds the register");
   end
   if (SEL_W < 1 || CTL_SEL_LSB + SEL_W > 32) begin : g_bad_sel
      $error("select field does not fit");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("ADDR_W must be at least 1");
   end
   if (FIXED_DIV < 0 || FIXED_DIV >= (1 << ACC_W)) begin : g_bad_fixed
      $error("FIXED_DIV out of range");
   end

   logic [31:0]      div_reg;
   logic [SEL_W-1:0] stg_sel;
   logic             wr_div, wr_ctl;
   logic             arm_main;
   logic             main_pend, main_fire;
   logic             pre_pend, pre_fire;
   logic             sel_fire;
   logic             pre_tick;
   logic [ACC_W-1:0] div_units;

   assign wr_div   = bus_wr && (bus_addr == ADDR_W'(REG_DIV));
   assign wr_ctl   = bus_wr && (bus_addr == ADDR_W'(REG_CTL));
   assign arm_main = wr_ctl && bus_wmask[CTL_TRIG] && bus_wdata[CTL_TRIG];

   // staged registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_reg <= '0;
      end else if (wr_div) begin
         div_reg <= (div_reg & ~(bus_wmask & WR_MASK)) |
                    (bus_wdata & bus_wmask & WR_MASK);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_sel <= '0;
      end else if (wr_ctl) begin
         stg_sel <= (stg_sel & ~bus_wmask[CTL_SEL_LSB +: SEL_W]) |
                    (bus_wdata[CTL_SEL_LSB +: SEL_W] & bus_wmask[CTL_SEL_LSB +: SEL_W]);
      end
   end

   // commit sequencers
   fracdiv_trig #(.LAT(COMMIT_LAT)) u_main_trig (
      .clk     (clk),
      .rst_n   (rst_n),
      .arm     (arm_main),
      .gate_on (gate_on),
      .pend    (main_pend),
      .fire    (main_fire)
   );

   if (PRE_TRIG_EN != 0) begin : g_pretrig
      logic arm_pre;
      assign arm_pre = wr_ctl && bus_wmask[CTL_PRE] && bus_wdata[CTL_PRE];
      fracdiv_trig #(.LAT(COMMIT_LAT)) u_pre_trig (
         .clk     (clk),
         .rst_n   (rst_n),
         .arm     (arm_pre),
         .gate_on (gate_on),
         .pend    (pre_pend),
         .fire    (pre_fire)
      );
      assign sel_fire = pre_fire;
   end else begin : g_nopretrig
      assign pre_pend = 1'b0;
      assign pre_fire = 1'b0;
      assign sel_fire = main_fire;
   end

   // active parent select
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        sel_out <= '0;
      else if (sel_fire) sel_out <= stg_sel;
   end

   // active divisor
   if (FIXED_DIV > 0) begin : g_fixed
      assign div_units = ACC_W'(FIXED_DIV);

      // R6: the divisor field can never be written
      p_field_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
         div_reg[FIELD_SHIFT +: FIELD_W] == '0);
   end else begin : g_prog
      logic [FIELD_W-1:0] act_field;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         act_field <= '0;
         else if (main_fire) act_field <= div_reg[FIELD_SHIFT +: FIELD_W];
      end

      assign div_units = ACC_W'(act_field) + ACC_W'(ONE);

      // R3: the running divisor moves only on a main commit
      p_active_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
         !main_fire |=> $stable(act_field));
   end

   // pulse generation
   fracdiv_pretick #(.PRE_DIV(PRE_DIV)) u_pretick (
      .clk     (clk),
      .rst_n   (rst_n),
      .gate_on (gate_on),
      .restart (main_fire | pre_fire),
      .tick    (pre_tick)
   );

   fracdiv_accum #(.ACC_W(ACC_W), .STEP(STEP)) u_accum (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv     (gate_on & pre_tick),
      .restart (main_fire | pre_fire),
      .div     (div_units),
      .ce      (ce_out)
   );

   // register read
   always_comb begin
      bus_rdata = '0;
      if (bus_raddr == ADDR_W'(REG_DIV)) begin
         bus_rdata = div_reg;
      end else if (bus_raddr == ADDR_W'(REG_CTL)) begin
         bus_rdata[CTL_SEL_LSB +: SEL_W] = stg_sel;
         bus_rdata[CTL_TRIG]             = main_pend;
         bus_rdata[CTL_PRE]              = pre_pend;
      end
   end

   // R2: unmasked bits of the divisor register keep their value
   p_mask_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_div |=> ((div_reg & ~$past(bus_wmask)) == ($past(div_reg) & ~$past(bus_wmask))));
   // R5: no pulse follows a gated-off cycle
   p_gate_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !gate_on |=> !ce_out);
   // R7: every pulse follows a gated pre-divider tick
   p_ce_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ce_out |-> $past(pre_tick && gate_on));
   // R8: the select output changes only on its own commit
   p_sel_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_fire |=> $stable(sel_out));
endmodule

// File: tb/fracdiv_ce_tb.sv
module fracdiv_ce_tb;
   localparam int CLK_PERIOD = 10;
   localparam int PRE  = 3;
   localparam int ONEQ = 4;
   localparam logic [31:0] FMASK = 32'h0000_00F0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        gate_on = 1'b1;
   logic        wr_a = 1'b0, wr_b = 1'b0;
   logic [1:0]  waddr = '0, raddr = '0;
   logic [31:0] wdata = '0, wmask = '0;
   logic [31:0] rdata_a, rdata_b;
   logic        ce_a, ce_b;
   logic [1:0]  sel_a, sel_b;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fracdiv_ce #(.FIELD_W(4), .FRAC_W(2), .FIELD_SHIFT(4), .PRE_DIV(PRE), .FIXED_DIV(0),
                .SEL_W(2), .PRE_TRIG_EN(1), .COMMIT_LAT(2), .ADDR_W(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .gate_on(gate_on), .bus_wr(wr_a), .bus_addr(waddr),
      .bus_wdata(wdata), .bus_wmask(wmask), .bus_raddr(raddr), .bus_rdata(rdata_a),
      .ce_out(ce_a), .sel_out(sel_a));

   fracdiv_ce #(.FIELD_W(4), .FRAC_W(2), .FIELD_SHIFT(4), .PRE_DIV(1), .FIXED_DIV(3),
                .SEL_W(2), .PRE_TRIG_EN(0), .COMMIT_LAT(2), .ADDR_W(2)) u_fix (
      .clk(clk), .rst_n(rst_n), .gate_on(gate_on), .bus_wr(wr_b), .bus_addr(waddr),
      .bus_wdata(wdata), .bus_wmask(wmask), .bus_raddr(raddr), .bus_rdata(rdata_b),
      .ce_out(ce_b), .sel_out(sel_b));

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic bus_write(input bit to_b, input int addr, input logic [31:0] d,
                            input logic [31:0] m);
      @(negedge clk);
      waddr = addr[1:0];
      wdata = d;
      wmask = m;
      wr_a  = !to_b;
      wr_b  = to_b;
      @(posedge clk);
      #1;
      wr_a = 1'b0;
      wr_b = 1'b0;
   endtask

   task automatic read_reg(input bit from_b, input int addr, output logic [31:0] d);
      raddr = addr[1:0];
      #1;
      d = from_b ? rdata_b : rdata_a;
   endtask

   // called just after the write edge; ends just after the commit edge
   task automatic commit_check(input bit from_b, input int bi, input string req);
      logic [31:0] d;
      read_reg(from_b, 1, d);
      chk(d[bi] == 1'b1, req, "commit bit after write edge", 32'(d[bi]), 1);
      @(posedge clk); #1;
      read_reg(from_b, 1, d);
      chk(d[bi] == 1'b1, req, "commit bit one edge later", 32'(d[bi]), 1);
      @(posedge clk); #1;
      read_reg(from_b, 1, d);
      chk(d[bi] == 1'b0, req, "commit bit at commit edge", 32'(d[bi]), 0);
   endtask

   // per-cycle comparison starting from the edge after a commit
   task automatic pattern(input bit from_b, input int dq, input int pre, input int step,
                          input int ncyc, input string req);
      int miss = 0;
      for (int k = 1; k <= ncyc; k++) begin
         int  j;
         bit  e;
         logic act;
         @(posedge clk); #1;
         j = k / pre;
         e = (k % pre == 0) && (((j * step) / dq) != (((j - 1) * step) / dq));
         act = from_b ? ce_b : ce_a;
         if (act !== e) miss++;
      end
      chk(miss == 0, req, $sformatf("pulse sequence D=%0d", dq), 32'(miss), 0);
   endtask

   task automatic count_pulses(input bit from_b, input int ncyc, output int n);
      n = 0;
      for (int k = 0; k < ncyc; k++) begin
         @(posedge clk); #1;
         if ((from_b ? ce_b : ce_a) === 1'b1) n++;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      int n;
      int miss;

      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      @(posedge clk); #1;

      // R9: reset state
      read_reg(0, 0, d); chk(d == 32'h0, "R9", "divisor reg", d, 32'h0);
      read_reg(0, 1, d); chk(d == 32'h0, "R9", "control reg", d, 32'h0);
      chk(sel_a == 2'd0, "R9", "sel_out", 32'(sel_a), 0);
      read_reg(1, 0, d); chk(d == 32'h0, "R9", "fixed divisor reg", d, 32'h0);
      // R9/R7: divide by 1.0 behind a /3 pre-divider -> one pulse per 3 cycles
      count_pulses(0, 30, n);
      chk(n == 10, "R7", "pulses in 30 cycles at reset divisor", 32'(n), 10);

      // R2: masked writes
      bus_write(0, 0, 32'hFFFF_FFFF, ~FMASK);
      read_reg(0, 0, d); chk(d == 32'hFFFF_FF0F, "R2", "spare bits only", d, 32'hFFFF_FF0F);
      bus_write(0, 0, 32'h0000_0050, FMASK);
      read_reg(0, 0, d); chk(d == 32'hFFFF_FF5F, "R2", "field only", d, 32'hFFFF_FF5F);

      // R1/R4/R7: sweep every field value
      for (int f = 0; f < 16; f++) begin
         bus_write(0, 0, 32'(f) << 4, FMASK);
         bus_write(0, 1, 32'h1, 32'h1);
         commit_check(0, 0, "R4");
         pattern(0, f + ONEQ, PRE, ONEQ, 60, "R1");
      end
      read_reg(0, 0, d); chk(d == 32'hFFFF_FFFF, "R2", "after sweep", d, 32'hFFFF_FFFF);

      // R3: staged value without commit leaves rate at D=19 quarters
      bus_write(0, 0, 32'h0, FMASK);
      read_reg(0, 0, d); chk(d == 32'hFFFF_FF0F, "R3", "staged field visible", d, 32'hFFFF_FF0F);
      count_pulses(0, 57, n);
      chk(n == 4, "R3", "pulses per 19 ticks, old divisor", 32'(n), 4);

      // R5: gate off holds the commit and silences output
      @(negedge clk) gate_on = 1'b0;
      bus_write(0, 0, 32'h70, FMASK);
      bus_write(0, 1, 32'h1, 32'h1);
      miss = 0;
      for (int k = 0; k < 8; k++) begin
         @(posedge clk); #1;
         if (ce_a !== 1'b0) miss++;
      end
      chk(miss == 0, "R5", "pulses while gated off", 32'(miss), 0);
      read_reg(0, 1, d); chk(d[0] == 1'b1, "R5", "commit pending while gated", 32'(d[0]), 1);
      @(negedge clk) gate_on = 1'b1;
      @(posedge clk); #1;
      read_reg(0, 1, d); chk(d[0] == 1'b1, "R5", "pending one edge after gate on", 32'(d[0]), 1);
      @(posedge clk); #1;
      read_reg(0, 1, d); chk(d[0] == 1'b0, "R5", "commit done after gate on", 32'(d[0]), 0);
      pattern(0, 11, PRE, ONEQ, 45, "R5");

      // R8: select commits only through the parent commit
      bus_write(0, 1, 32'h200, 32'h300);
      read_reg(0, 1, d); chk(d == 32'h200, "R8", "staged select", d, 32'h200);
      bus_write(0, 1, 32'h1, 32'h1);
      commit_check(0, 0, "R8");
      chk(sel_a == 2'd0, "R8", "sel_out after main commit", 32'(sel_a), 0);
      bus_write(0, 1, 32'h2, 32'h2);
      commit_check(0, 1, "R8");
      chk(sel_a == 2'd2, "R8", "sel_out after parent commit", 32'(sel_a), 2);

      // R6: fixed variant
      bus_write(1, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
      read_reg(1, 0, d); chk(d == 32'hFFFF_FF0F, "R6", "field not writable", d, 32'hFFFF_FF0F);
      bus_write(1, 1, 32'h103, 32'h303);
      commit_check(1, 0, "R6");
      read_reg(1, 1, d); chk(d == 32'h100, "R8", "no parent commit bit in fixed variant", d, 32'h100);
      chk(sel_b == 2'd1, "R8", "main commit applies select", 32'(sel_b), 1);
      pattern(1, 3, 1, 1, 30, "R6");

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule